// File: doc/BRIEF.md
# Timer Clock Output Selector

This block takes two timers and builds the signal that drives an external clock pin from one of them. Each timer supplies a one-cycle underflow strobe and a PWM waveform. Control bits choose the lower or upper timer, put the pair into cascade mode, select PWM mode, and enable the pin.

In normal mode, the block keeps a toggle flop. The flop flips on every underflow of the chosen timer, so the pin runs at half the underflow rate. In PWM mode, the chosen timer's PWM waveform goes straight to the pin. Cascade mode joins the two timers into one wide counter, so the upper timer is always the source. The output is a single register, so mode and source changes never produce glitches on the pin. While the pin is disabled it is held low.

Top module: `tout_sel`

## Requirements
- R1: After reset, `clk_out` is 0.
- R2: While `out_en` is 0, `clk_out` is 0 on the following cycle and the toggle is cleared. After `out_en` returns to 1, the first underflow of the source drives `clk_out` to 1.
- R3: In normal mode (`pwm_mode` = 0), with the pin enabled and the source unchanged, each underflow strobe of the source inverts `clk_out` one clock later. A cycle without such a strobe leaves `clk_out` unchanged.
- R4: An underflow strobe on the timer that is not the source has no effect on `clk_out`.
- R5: With `cascade_en` = 0, `sel_upper` = 0 makes the lower timer the source and `sel_upper` = 1 makes the upper timer the source.
- R6: With `cascade_en` = 1, the upper timer is the source whatever `sel_upper` holds.
- R7: In PWM mode (`pwm_mode` = 1), with the pin enabled, `clk_out` equals the source's PWM input from one clock earlier.
- R8: In a cycle where the effective source differs from the previous cycle's, the toggle is cleared. Any underflow in that cycle is ignored, and in normal mode `clk_out` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uf_lower | input | 1 | Underflow strobe of the lower timer |
| uf_upper | input | 1 | Underflow strobe of the upper timer |
| pwm_lower | input | 1 | PWM waveform of the lower timer |
| pwm_upper | input | 1 | PWM waveform of the upper timer |
| pwm_mode | input | 1 | 1: pass PWM waveform; 0: divide underflow by two |
| cascade_en | input | 1 | 1: timers cascaded, upper timer forced as source |
| sel_upper | input | 1 | Source select, 0 lower timer, 1 upper timer |
| out_en | input | 1 | Pin enable |
| clk_out | output | 1 | Registered pin output |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus, because only one register stands between any input and `clk_out`. This covers a toggle on an underflow, a PWM level, the forced low on disable and the clear on a source change. The bench applies inputs on the falling edge. It then waits through one rising edge and compares at the next falling edge against a cycle-level model built from the requirements. A long pseudo-random sweep over all eight control and strobe inputs follows the directed cases. Each comparison is tagged with the requirement that governs that cycle.

// File: rtl/tout_sel.sv
module tout_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic uf_lower,
  input  logic uf_upper,
  input  logic pwm_lower,
  input  logic pwm_upper,
  input  logic pwm_mode,
  input  logic cascade_en,
  input  logic sel_upper,
  input  logic out_en,
  output logic clk_out
);

  logic src, src_q, chg;
  logic uf_pick, pwm_pick;
  logic tog_q, tog_d, out_q;

  // cascade forces the upper timer (R6)
  assign src      = cascade_en | sel_upper;
  assign uf_pick  = src ? uf_upper  : uf_lower;
  assign pwm_pick = src ? pwm_upper : pwm_lower;
  assign chg      = src ^ src_q;
  assign tog_d    = (out_en && !chg) ? (tog_q ^ uf_pick) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      tog_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      src_q <= src;
      tog_q <= tog_d;
      out_q <= out_en & (pwm_mode ? pwm_pick : tog_d);
    end
  end

  assign clk_out = out_q;

endmodule

module tout_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic uf_lower,
  input logic uf_upper,
  input logic pwm_lower,
  input logic pwm_upper,
  input logic pwm_mode,
  input logic cascade_en,
  input logic sel_upper,
  input logic out_en,
  input logic clk_out
);

  logic armed;
  logic eff, uf_eff, pwm_eff, norm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assign eff     = cascade_en | sel_upper;
  assign uf_eff  = eff ? uf_upper : uf_lower;
  assign pwm_eff = eff ? pwm_upper : pwm_lower;
  assign norm    = out_en && !pwm_mode;

  // R2
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !clk_out);

  // R7
  pwm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && pwm_mode) |=> (clk_out == $past(pwm_eff)));

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (norm && $past(norm) && eff == $past(eff) && uf_eff) |=> (clk_out != $past(clk_out)));

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (norm && $past(norm) && eff == $past(eff) && !uf_eff) |=> $stable(clk_out));

  // R8
  src_change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (norm && eff != $past(eff)) |=> !clk_out);

endmodule

bind tout_sel tout_sel_chk i_chk (.*);

// File: tb/test_tout_sel.sv
module test_tout_sel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uf_lower = 0, uf_upper = 0, pwm_lower = 0, pwm_upper = 0;
  logic pwm_mode = 0, cascade_en = 0, sel_upper = 0, out_en = 0;
  logic clk_out;

  int checks = 0;
  int errors = 0;

  logic m_tog = 0, m_src = 0, m_out = 0;

  always #10 clk = ~clk;

  tout_sel i_tout_sel (
    .clk(clk), .rst_n(rst_n),
    .uf_lower(uf_lower), .uf_upper(uf_upper),
    .pwm_lower(pwm_lower), .pwm_upper(pwm_upper),
    .pwm_mode(pwm_mode), .cascade_en(cascade_en),
    .sel_upper(sel_upper), .out_en(out_en),
    .clk_out(clk_out)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (clk_out !== exp) begin
      errors++;
      $display("FAIL %s: clk_out=%b expected=%b at %0t", req, clk_out, exp, $time);
    end
  endtask

  // vec bits: 7 en, 6 pm, 5 cas, 4 sel, 3 ph, 2 pl, 1 uh, 0 ul
  task automatic step(input logic [7:0] v, input string force_tag);
    logic eff, chg, nt;
    string tag;
    {out_en, pwm_mode, cascade_en, sel_upper, pwm_upper, pwm_lower, uf_upper, uf_lower} = v;
    eff = v[5] | v[4];
    chg = eff != m_src;
    nt  = (!v[7] || chg) ? 1'b0 : (m_tog ^ (eff ? v[1] : v[0]));
    m_out = !v[7] ? 1'b0 : (v[6] ? (eff ? v[3] : v[2]) : nt);
    m_tog = nt;
    m_src = eff;
    if (force_tag != "") tag = force_tag;
    else if (!v[7]) tag = "R2";
    else if (v[6]) tag = "R7";
    else if (chg) tag = "R8";
    else if (eff ? v[1] : v[0]) tag = v[5] ? "R6" : "R3";
    else tag = "R4";
    @(posedge clk);
    @(negedge clk);
    check(tag, m_out);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: expired, expected run to complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // R5: lower selected, upper strobes ignored, lower strobe toggles
    step(8'b1000_0000, "R5");
    step(8'b1000_0010, "R4");
    step(8'b1000_0001, "R5");
    step(8'b1000_0000, "R3");
    step(8'b1000_0001, "R3");
    // select upper: change clears
    step(8'b1001_0011, "R8");
    step(8'b1001_0010, "R5");
    step(8'b1001_0001, "R4");
    // R6: cascade with sel 0 keeps upper, no change event
    step(8'b1010_0010, "R6");
    step(8'b1010_0001, "R6");
    step(8'b1010_0010, "R6");
    // R2: disable then re-enable
    step(8'b0010_0010, "R2");
    step(8'b0010_0000, "R2");
    step(8'b1010_0010, "R2");
    // R7: pwm upper and lower
    step(8'b1110_1000, "R7");
    step(8'b1110_0100, "R7");
    step(8'b1100_0100, "R7");
    step(8'b1100_1000, "R7");

    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] v;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v = lf[7:0];
      v[7] = (lf[11:9] != 3'd0);
      v[5] = v[5] & lf[12] & lf[13];
      if (lf[14] & lf[15]) v[4] = m_src & ~v[5];
      step(v, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule